// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer placed in front of a successive-approximation converter. A control write loads a set of mode bits: single or multichannel operation, a sequence length of four or eight steps, a single-shot option, internal or external source selection, a three-bit start code and a continuous-scan option. The controller then walks a sequence of result slots. For each slot it picks a source, pulses a start request to the converter, waits for the converter's done strobe and stores the returned sample in that slot.

In multichannel mode the start code opens a window of inputs that rotates modulo eight, or modulo four inside a group of four in the short sequence, so each slot is tied to a rotated channel. With multichannel off, the same channel is sampled repeatedly. Internal sources (high reference, low reference, midpoint) use the same selection path. A code with no assigned internal source skips the converter and stores zero. Results are read back through a registered read port. A completion flag shows when the last slot of the sequence has been filled.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `conv_start` and `seq_done` are 0, and no start request is issued until a control write occurs.
- R2: Each conversion step raises `conv_start` for exactly one clock. `conv_sel` holds its value until `conv_done` is seen, and the `conv_data` sampled with `conv_done` is stored in the current slot.
- R3: With multichannel set, eight-step length and external sources, slot n receives the conversion of channel (code + n) mod 8, and the steps are issued in slot order 0..7.
- R4: With multichannel set, four-step length and external sources, only slots 0..3 are written. Slot n uses channel {code[2], (code[1:0] + n) mod 4}. Slots 4..7 keep their earlier contents.
- R5: With multichannel clear, the sequence performs eight conversions (length bit set) or four conversions (length bit clear) of the one channel given by the code, into slots 0..7 or 0..3.
- R6: With the length bit clear and the single-shot bit set, exactly one conversion of the code's channel is made into slot 0, whatever the multichannel bit.
- R7: `conv_sel` = {internal bit, channel}. With the internal bit set, channel codes 100, 101 and 110 select the high reference, the low reference and the midpoint and are converted. Codes 000–011 and 111 are reserved: they issue no start and write zero to their slot.
- R8: `seq_done` rises after the last slot of the sequence is written and reads 0 in the cycle after any control write.
- R9: A control write during a sequence abandons it. The new sequence begins at slot 0 with the new settings, and a done strobe that belongs to the abandoned step is not used.
- R10: With the scan bit set, the sequence restarts from slot 0 right after it completes. With it clear, the controller stays idle and issues no further start requests.
- R11: `rd_data` presents the contents of slot `rd_idx` one clock after `rd_idx` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control write strobe; loads the mode bits and (re)starts the sequence |
| cfg_scan | input | 1 | Continuous scan enable |
| cfg_multi | input | 1 | Multichannel (rotating) mode |
| cfg_len8 | input | 1 | Eight steps when 1, four when 0 |
| cfg_single | input | 1 | Single conversion when the length bit is 0 |
| cfg_internal | input | 1 | Select internal reference sources |
| cfg_code | input | 3 | Start channel code, most significant bit first |
| conv_start | output | 1 | One-clock start request to the converter |
| conv_sel | output | 4 | Source select {internal, channel} |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| rd_idx | input | 3 | Result slot to read |
| rd_data | output | 10 | Registered read data |
| seq_done | output | 1 | Sequence complete flag |

## Verification
A wrong slot counter or a wrong rotation appears at the ports as an unexpected `conv_sel` on the very next start pulse, or as a result landing in a neighbouring slot that is visible one read later. A wrong length or a wrong reserved-code decision changes the number of start pulses before `seq_done` rises, so comparing the pulse count and the select sequence of every run against a model computed from the mode bits catches it within one sequence. Abort and scan faults show up as stale data in slot 0, as a missing flag clear in the cycle after a write, or as start pulses that continue once scan is off.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CODE_W = 3;

  typedef struct packed {
    logic              scan;
    logic              multi;
    logic              len8;
    logic              single;
    logic              internal;
    logic [CODE_W-1:0] code;
  } seq_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_t;

endpackage

// File: rtl/adc_chan_map.sv
module adc_chan_map
  import adc_seq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  seq_cfg_t           cfg,
  input  logic [IDX_W-1:0]   slot,
  output logic [CODE_W:0]    sel,
  output logic               reserved
);

  localparam int HALF_W = CODE_W - 1;

  logic [CODE_W-1:0] ch;
  logic              rotate;

  always_comb begin
    rotate = cfg.multi && !(cfg.single && !cfg.len8);
    ch     = cfg.code;
    if (rotate) begin
      if (cfg.len8) begin
        ch = cfg.code + CODE_W'(slot);
      end else begin
        ch = {cfg.code[CODE_W-1], cfg.code[HALF_W-1:0] + HALF_W'(slot)};
      end
    end
    sel      = {cfg.internal, ch};
    // internal codes: 100 high ref, 101 low ref, 110 midpoint; others reserved
    reserved = cfg.internal && (!ch[CODE_W-1] || (&ch));
  end

endmodule

// File: rtl/adc_result_ram.sv
module adc_result_ram #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  seq_cfg_t         cfg_in,
  input  logic             conv_done,
  input  logic [CODE_W:0]  ch_sel,
  input  logic             ch_reserved,
  output seq_cfg_t         cfg_q,
  output logic [IDX_W-1:0] slot,
  output logic             conv_start,
  output logic [CODE_W:0]  conv_sel,
  output logic             wr_en,
  output logic             wr_zero,
  output logic             seq_done
);

  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(NSLOT - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(NSLOT / 2 - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] last_slot;
  logic             step_ok;

  always_comb begin
    if (cfg_q.single && !cfg_q.len8) last_slot = '0;
    else if (cfg_q.len8)             last_slot = LAST_LONG;
    else                             last_slot = LAST_SHORT;

    step_ok = 1'b0;
    wr_en   = 1'b0;
    wr_zero = 1'b0;
    if (!cfg_wr) begin
      if (state == ST_ISSUE && ch_reserved) begin
        wr_en   = 1'b1;
        wr_zero = 1'b1;
        step_ok = 1'b1;
      end else if (state == ST_WAIT && conv_done) begin
        wr_en   = 1'b1;
        step_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      slot       <= '0;
      conv_start <= 1'b0;
      conv_sel   <= '0;
      seq_done   <= 1'b0;
      cfg_q      <= '0;
    end else begin
      conv_start <= 1'b0;
      if (cfg_wr) begin
        cfg_q    <= cfg_in;
        slot     <= '0;
        seq_done <= 1'b0;
        state    <= ST_ISSUE;
      end else begin
        if (state == ST_ISSUE && !ch_reserved) begin
          conv_start <= 1'b1;
          conv_sel   <= ch_sel;
          state      <= ST_WAIT;
        end
        if (step_ok) begin
          if (slot == last_slot) begin
            seq_done <= 1'b1;
            slot     <= '0;
            state    <= cfg_q.scan ? ST_ISSUE : ST_IDLE;
          end else begin
            slot  <= slot + 1'b1;
            state <= ST_ISSUE;
          end
        end
      end
    end
  end

  // R2: start request lasts one clock
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R2: select held while the converter works
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !conv_done && !cfg_wr) |=> $stable(conv_sel));

  // R7: reserved internal codes never reach the converter
  p_no_reserved_start_r7: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !(conv_sel[CODE_W] &&
                     (!conv_sel[CODE_W-1] || (&conv_sel[CODE_W-1:0]))));

  // R5: slot index stays inside the selected length
  p_slot_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (slot <= last_slot));

  // R9: a control write restarts at slot 0 with the flag clear
  p_abort_restart_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (slot == '0 && !seq_done && state == ST_ISSUE));

  // R10: without scan the controller idles after completion
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (rst)
    ($rose(seq_done) && !cfg_q.scan) |-> (state == ST_IDLE));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NSLOT  = 8,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_scan,
  input  logic              cfg_multi,
  input  logic              cfg_len8,
  input  logic              cfg_single,
  input  logic              cfg_internal,
  input  logic [2:0]        cfg_code,
  output logic              conv_start,
  output logic [3:0]        conv_sel,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              seq_done
);

  seq_cfg_t          cfg_in;
  seq_cfg_t          cfg_q;
  logic [IDX_W-1:0]  slot;
  logic [CODE_W:0]   ch_sel;
  logic              ch_reserved;
  logic              wr_en;
  logic              wr_zero;
  logic [DATA_W-1:0] wr_data;

  assign cfg_in = '{scan: cfg_scan, multi: cfg_multi, len8: cfg_len8,
                    single: cfg_single, internal: cfg_internal, code: cfg_code};

  adc_chan_map #(.IDX_W(IDX_W)) u_map (
    .cfg      (cfg_q),
    .slot     (slot),
    .sel      (ch_sel),
    .reserved (ch_reserved)
  );

  adc_seq_fsm #(.NSLOT(NSLOT)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_in      (cfg_in),
    .conv_done   (conv_done),
    .ch_sel      (ch_sel),
    .ch_reserved (ch_reserved),
    .cfg_q       (cfg_q),
    .slot        (slot),
    .conv_start  (conv_start),
    .conv_sel    (conv_sel),
    .wr_en       (wr_en),
    .wr_zero     (wr_zero),
    .seq_done    (seq_done)
  );

  assign wr_data = wr_zero ? '0 : conv_data;

  adc_result_ram #(.DATA_W(DATA_W), .DEPTH(NSLOT)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (slot),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_scan = 1'b0, cfg_multi = 1'b0, cfg_len8 = 1'b0;
  logic       cfg_single = 1'b0, cfg_internal = 1'b0;
  logic [2:0] cfg_code = '0;
  logic       conv_start;
  logic [3:0] conv_sel;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic [2:0] rd_idx = '0;
  logic [9:0] rd_data;
  logic       seq_done;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_scan(cfg_scan),
    .cfg_multi(cfg_multi), .cfg_len8(cfg_len8), .cfg_single(cfg_single),
    .cfg_internal(cfg_internal), .cfg_code(cfg_code),
    .conv_start(conv_start), .conv_sel(conv_sel), .conv_done(conv_done),
    .conv_data(conv_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .seq_done(seq_done)
  );

  // converter model: result derived from the select, done three cycles later
  logic [3:0] log_sel [64];
  int         nlog = 0;
  logic       pend = 1'b0;
  int         cnt  = 0;
  logic [3:0] cur;

  function automatic logic [9:0] dat(logic [3:0] s);
    return {s, 2'b10, s};
  endfunction

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (conv_start) begin
      if (nlog < 64) log_sel[nlog] = conv_sel;
      nlog = nlog + 1;
      cur  = conv_sel;
      pend = 1'b1;
      cnt  = 3;
    end else if (cfg_wr) begin
      pend = 1'b0;
    end else if (pend) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        conv_done = 1'b1;
        conv_data = dat(cur);
        pend      = 1'b0;
      end
    end
  end

  // cfg byte: {scan, multi, len8, single, internal, code[2:0]}
  function automatic int steps_of(logic [7:0] c);
    if (c[4] && !c[5]) return 1;
    return c[5] ? 8 : 4;
  endfunction

  function automatic logic [3:0] exp_sel(logic [7:0] c, int n);
    logic [2:0] ch;
    logic [2:0] nn;
    nn = 3'(n);
    ch = c[2:0];
    if (c[6] && !(c[4] && !c[5])) begin
      if (c[5]) ch = c[2:0] + nn;
      else      ch = {c[2], c[1:0] + nn[1:0]};
    end
    return {c[3], ch};
  endfunction

  function automatic logic exp_res(logic [3:0] s);
    return s[3] && (!s[2] || s[2:0] == 3'b111);
  endfunction

  function automatic string tag_of(logic [7:0] c);
    if (c[3])            return "R7";
    if (c[4] && !c[5])   return "R6";
    if (!c[6])           return "R5";
    return c[5] ? "R3" : "R4";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [9:0] d);
    @(negedge clk); #1 rd_idx = 3'(idx);
    @(negedge clk); d = rd_data;
  endtask

  task automatic write_cfg(logic [7:0] c);
    @(negedge clk); #1;
    {cfg_scan, cfg_multi, cfg_len8, cfg_single, cfg_internal, cfg_code} = c;
    cfg_wr = 1'b1;
    nlog   = 0;
    @(negedge clk);
    check(seq_done == 1'b0, "R8", "flag after write", seq_done, 0);
    #1 cfg_wr = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!seq_done && k < 400) begin
      @(negedge clk);
      k++;
    end
    check(seq_done == 1'b1, "R8", "flag at end", seq_done, 1);
  endtask

  // vectors: {cfg byte, expected number of start pulses}
  localparam logic [11:0] VEC [10] = '{
    {8'b0_1_1_0_0_101, 4'd8},  // rotate 8, code 5
    {8'b0_1_0_0_0_110, 4'd4},  // rotate 4, code 6
    {8'b0_1_1_0_0_000, 4'd8},  // rotate 8, code 0
    {8'b0_1_0_0_0_001, 4'd4},  // rotate 4, code 1
    {8'b0_0_1_0_0_011, 4'd8},  // repeat 8, channel 3
    {8'b0_0_0_0_0_010, 4'd4},  // repeat 4, channel 2
    {8'b0_1_0_1_0_111, 4'd1},  // single, channel 7
    {8'b0_0_0_0_1_110, 4'd4},  // internal midpoint x4
    {8'b0_1_1_0_1_100, 4'd3},  // internal rotate from high ref
    {8'b0_0_0_1_1_001, 4'd0}   // internal reserved, single
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] prev [8];
    logic [9:0] d;
    logic [7:0] c;
    int         n_exp;
    int         j;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R1: reset state and no activity
    check(conv_start == 1'b0, "R1", "start after reset", conv_start, 0);
    check(seq_done == 1'b0,   "R1", "flag after reset", seq_done, 0);
    repeat (10) @(negedge clk);
    check(nlog == 0, "R1", "starts while idle", nlog, 0);

    for (int v = 0; v < 10; v++) begin
      c     = VEC[v][11:4];
      n_exp = int'(VEC[v][3:0]);
      for (int s = 0; s < 8; s++) rd(s, prev[s]);
      write_cfg(c);
      wait_done();
      repeat (4) @(negedge clk);
      check(nlog == n_exp, tag_of(c), "start count", nlog, n_exp);
      j = 0;
      for (int n = 0; n < steps_of(c); n++) begin
        if (!exp_res(exp_sel(c, n))) begin
          check(log_sel[j] == exp_sel(c, n), "R2", "select order",
                log_sel[j], exp_sel(c, n));
          j++;
        end
      end
      for (int s = 0; s < 8; s++) begin
        logic [9:0] e;
        rd(s, d);
        if (s < steps_of(c)) e = exp_res(exp_sel(c, s)) ? 10'd0 : dat(exp_sel(c, s));
        else                 e = prev[s];
        check(d === e, {tag_of(c), "/R11"}, "slot content", d, e);
      end
    end

    // R9: abort a running rotate-8 after three starts, restart rotate-4 code 2
    write_cfg(8'b0_1_1_0_0_000);
    j = 0;
    while (nlog < 3 && j < 200) begin @(negedge clk); j++; end
    write_cfg(8'b0_1_0_0_0_010);
    wait_done();
    repeat (4) @(negedge clk);
    check(nlog == 4, "R9", "starts after abort", nlog, 4);
    check(log_sel[0] == 4'd2, "R9", "first select after abort", log_sel[0], 2);
    rd(0, d);
    check(d == dat(4'd2), "R9", "slot 0 after abort", d, dat(4'd2));
    rd(3, d);
    check(d == dat(4'd1), "R9", "slot 3 after abort", d, dat(4'd1));

    // R10: scan keeps restarting, then stops once scan is cleared
    write_cfg(8'b1_0_0_1_0_011);
    repeat (60) @(negedge clk);
    check(nlog >= 3, "R10", "scan restarts", nlog, 3);
    write_cfg(8'b0_0_0_1_0_011);
    wait_done();
    repeat (40) @(negedge clk);
    check(nlog == 1, "R10", "idle after single", nlog, 1);
    check(conv_start == 1'b0, "R10", "no start when idle", conv_start, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule